// File: doc/BRIEF.md
# Calendar Alarm Comparator

This block holds a host-programmed alarm time (month, date, hour, minute and second) and compares it with a running calendar that an external time counter supplies. The comparison happens only on the once-per-second update tick. Each alarm byte carries its own wildcard bit. Masking fields from the most significant one downward turns the alarm into a repeating event: monthly, daily, hourly, every minute or every second. A match latches an alarm flag. The flag appears in a shared status byte together with two externally owned status bits: a watchdog event and a low-battery indication.

The interrupt output is active low and is meant to drive an open-drain pad. It is pulled low while the flag is set and the global alarm enable is on. The enable gates only the output, never the flag. The host clears the flag by reading the status byte. A bus lockout input models a power-fail write protection window. While it is high, host reads and writes have no effect, but alarm matching, the flag and the interrupt keep running, as they do in battery-backed operation.

Top module: `cal_alarm_cmp`

## Requirements
- R1: After reset, every alarm byte reads 0x00, the flag and the enable are clear, `irq_n` is 1 and `rd_data` is 0x00.
- R2: A write to address 1, 2, 3, 4 or 5 stores the byte as the second, minute, hour, date or month alarm respectively. A read with `rd_en` presents the stored byte on `rd_data` after the next rising edge.
- R3: On a clock edge with `sec_tick` high and every unmasked field matching, the alarm flag sets. It reads back as bit 6 of the status byte at address 0.
- R4: With `sec_tick` low, the flag never sets, even when the alarm bytes equal the calendar.
- R5: An alarm byte with bit 7 set is a wildcard and is left out of the comparison. With all five bytes masked, every tick sets the flag.
- R6: For an unmasked field, bits 6:0 of the alarm byte, extended with a zero in bit 7, must equal the whole calendar byte. Any unequal unmasked field prevents the flag from setting.
- R7: A read of address 0 returns the flag and clears it at the same edge, and `irq_n` returns high after that edge. Reads of any other address leave the flag alone.
- R8: `irq_n` is low exactly while the flag is set and the enable (status byte bit 5, written through address 0) is 1. The flag sets whether or not the enable is on.
- R9: The status byte reads as bit 7 = `wdog_flag` input, bit 6 = alarm flag, bit 5 = enable, bit 4 = `batt_low` input, and bits 3:0 = 0.
- R10: When a matching tick and a status read fall in the same cycle, the read returns the old flag and the flag ends up set.
- R11: While `bus_block` is high, writes change no register, reads neither update `rd_data` nor clear the flag, and matching and `irq_n` keep operating.
- R12: A write to address 0 changes only the enable, from data bit 5. Writes to addresses 6 and 7 have no effect, and reads of them return 0x00.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_block | input | 1 | Host access lockout (power-fail protection) |
| wr_en | input | 1 | Host write strobe |
| rd_en | input | 1 | Host read strobe |
| addr | input | 3 | Register address |
| wdata | input | 8 | Write data |
| rd_data | output | 8 | Registered read data |
| cal_month | input | 8 | Calendar month, BCD |
| cal_date | input | 8 | Calendar date, BCD |
| cal_hour | input | 8 | Calendar hour, BCD |
| cal_min | input | 8 | Calendar minute, BCD |
| cal_sec | input | 8 | Calendar second, BCD |
| sec_tick | input | 1 | One-cycle once-per-second update strobe |
| wdog_flag | input | 1 | Watchdog event status, shown in the status byte |
| batt_low | input | 1 | Battery status, shown in the status byte |
| irq_n | output | 1 | Active-low alarm interrupt, open-drain style |

## Verification
The assertions take three things for granted. `sec_tick` is a single-cycle strobe. The calendar inputs are stable around the tick. The host never issues a read and a write in the same cycle. The stimulus changes the calendar only on falling edges, while the tick is low. It pulses the tick for exactly one cycle and keeps read and write strobes in separate task calls. Lockout windows are entered and left on falling edges, so every assertion about register stability sees a whole blocked cycle.

// File: rtl/cal_alarm_cmp_pkg.sv
package cal_alarm_cmp_pkg;
  localparam int unsigned BYTE_W     = 8;
  localparam int unsigned NUM_FIELDS = 5;
  localparam int unsigned ADDR_W     = 3;

  // Register address map: status byte, then alarm fields second..month.
  localparam logic [ADDR_W-1:0] ADDR_STATUS     = 3'd0;
  localparam int unsigned       ADDR_ALARM_BASE = 1;

  // Status byte bit positions.
  localparam int unsigned ST_WDOG_BIT  = 7;
  localparam int unsigned ST_ALARM_BIT = 6;
  localparam int unsigned ST_EN_BIT    = 5;
  localparam int unsigned ST_BATT_BIT  = 4;

  // Wildcard bit inside each alarm byte.
  localparam int unsigned MASK_BIT = BYTE_W - 1;

  typedef logic [BYTE_W-1:0] byte_t;
endpackage

// File: rtl/cal_alarm_regs.sv
module cal_alarm_regs
  import cal_alarm_cmp_pkg::*;
#(
  parameter int unsigned FIELD_W   = BYTE_W,
  parameter int unsigned N_FIELDS  = NUM_FIELDS,
  parameter int unsigned AW        = ADDR_W,
  parameter int unsigned BASE_ADDR = ADDR_ALARM_BASE
) (
  input  logic                             clk,
  input  logic                             rst_n,
  input  logic                             wr_acc,
  input  logic [AW-1:0]                    addr,
  input  logic [FIELD_W-1:0]               wdata,
  output logic [N_FIELDS-1:0][FIELD_W-1:0] alarm_q,
  output logic                             en_q
);
  logic [N_FIELDS-1:0][FIELD_W-1:0] alarm_d;
  logic                             en_d;
  logic                             st_sel;

  assign st_sel = (addr == AW'(ADDR_STATUS));

  for (genvar i = 0; i < N_FIELDS; i++) begin : g_field
    logic fsel;
    assign fsel = (addr == AW'(BASE_ADDR + i));

    always_comb begin
      alarm_d[i] = alarm_q[i];
      if (wr_acc && fsel) begin
        alarm_d[i] = wdata;
      end
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        alarm_q[i] <= '0;
      end else begin
        alarm_q[i] <= alarm_d[i];
      end
    end
  end

  always_comb begin
    en_d = en_q;
    if (wr_acc && st_sel) begin
      en_d = wdata[ST_EN_BIT];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_q <= 1'b0;
    end else begin
      en_q <= en_d;
    end
  end
endmodule

// File: rtl/cal_alarm_match.sv
module cal_alarm_match
  import cal_alarm_cmp_pkg::*;
#(
  parameter int unsigned FIELD_W  = BYTE_W,
  parameter int unsigned N_FIELDS = NUM_FIELDS
) (
  input  logic [N_FIELDS-1:0][FIELD_W-1:0] alarm,
  input  logic [N_FIELDS-1:0][FIELD_W-1:0] cal,
  output logic                             match
);
  logic [N_FIELDS-1:0] hit;

  for (genvar i = 0; i < N_FIELDS; i++) begin : g_cmp
    logic [FIELD_W-1:0] want;
    assign want   = {1'b0, alarm[i][FIELD_W-2:0]};
    assign hit[i] = alarm[i][FIELD_W-1] || (want == cal[i]);
  end

  assign match = &hit;
endmodule

// File: rtl/cal_alarm_flag.sv
module cal_alarm_flag (
  input  logic clk,
  input  logic rst_n,
  input  logic tick,
  input  logic match,
  input  logic clr,
  input  logic en,
  output logic flag_q,
  output logic irq_n
);
  logic set;
  logic flag_d;

  assign set = tick && match;

  // A new match wins over a clearing read in the same cycle.
  always_comb begin
    flag_d = flag_q;
    if (set) begin
      flag_d = 1'b1;
    end else if (clr) begin
      flag_d = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      flag_q <= 1'b0;
    end else begin
      flag_q <= flag_d;
    end
  end

  assign irq_n = ~(flag_q && en);
endmodule

// File: rtl/cal_alarm_cmp.sv
module cal_alarm_cmp
  import cal_alarm_cmp_pkg::*;
#(
  parameter int unsigned FIELD_W = BYTE_W,
  parameter int unsigned AW      = ADDR_W
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               bus_block,
  input  logic               wr_en,
  input  logic               rd_en,
  input  logic [AW-1:0]      addr,
  input  logic [FIELD_W-1:0] wdata,
  output logic [FIELD_W-1:0] rd_data,
  input  logic [FIELD_W-1:0] cal_month,
  input  logic [FIELD_W-1:0] cal_date,
  input  logic [FIELD_W-1:0] cal_hour,
  input  logic [FIELD_W-1:0] cal_min,
  input  logic [FIELD_W-1:0] cal_sec,
  input  logic               sec_tick,
  input  logic               wdog_flag,
  input  logic               batt_low,
  output logic               irq_n
);
  localparam int unsigned NF       = NUM_FIELDS;
  localparam int unsigned LAST_ADR = ADDR_ALARM_BASE + NF - 1;

  // Reset: asserted asynchronously, released on a clock edge.
  logic rst_meta_q;
  logic rst_sync_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta_q <= 1'b0;
      rst_sync_n <= 1'b0;
    end else begin
      rst_meta_q <= 1'b1;
      rst_sync_n <= rst_meta_q;
    end
  end

  logic                       wr_acc;
  logic                       rd_acc;
  logic                       st_clr;
  logic [NF-1:0][FIELD_W-1:0] cal_vec;
  logic [NF-1:0][FIELD_W-1:0] alarm_w;
  logic                       en_w;
  logic                       match_w;
  logic                       flag_w;

  assign wr_acc  = wr_en && !bus_block;
  assign rd_acc  = rd_en && !bus_block;
  assign st_clr  = rd_acc && (addr == AW'(ADDR_STATUS));
  assign cal_vec = {cal_month, cal_date, cal_hour, cal_min, cal_sec};

  cal_alarm_regs #(
    .FIELD_W  (FIELD_W),
    .N_FIELDS (NF),
    .AW       (AW),
    .BASE_ADDR(ADDR_ALARM_BASE)
  ) u_regs (
    .clk    (clk),
    .rst_n  (rst_sync_n),
    .wr_acc (wr_acc),
    .addr   (addr),
    .wdata  (wdata),
    .alarm_q(alarm_w),
    .en_q   (en_w)
  );

  cal_alarm_match #(
    .FIELD_W (FIELD_W),
    .N_FIELDS(NF)
  ) u_match (
    .alarm(alarm_w),
    .cal  (cal_vec),
    .match(match_w)
  );

  cal_alarm_flag u_flag (
    .clk   (clk),
    .rst_n (rst_sync_n),
    .tick  (sec_tick),
    .match (match_w),
    .clr   (st_clr),
    .en    (en_w),
    .flag_q(flag_w),
    .irq_n (irq_n)
  );

  // Read path.
  logic [FIELD_W-1:0] status_byte;
  logic [FIELD_W-1:0] rd_mux;
  logic [FIELD_W-1:0] rd_d;
  logic [FIELD_W-1:0] rd_q;

  always_comb begin
    status_byte               = '0;
    status_byte[ST_WDOG_BIT]  = wdog_flag;
    status_byte[ST_ALARM_BIT] = flag_w;
    status_byte[ST_EN_BIT]    = en_w;
    status_byte[ST_BATT_BIT]  = batt_low;
  end

  always_comb begin
    rd_mux = '0;
    if (addr == AW'(ADDR_STATUS)) begin
      rd_mux = status_byte;
    end else begin
      for (int i = 0; i < int'(NF); i++) begin
        if (addr == AW'(ADDR_ALARM_BASE + i)) begin
          rd_mux = alarm_w[i];
        end
      end
    end
  end

  always_comb begin
    rd_d = rd_q;
    if (rd_acc) begin
      rd_d = rd_mux;
    end
  end

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) begin
      rd_q <= '0;
    end else begin
      rd_q <= rd_d;
    end
  end

  assign rd_data = rd_q;

  if (LAST_ADR >= (1 << AW)) begin : g_bad_map
    initial $error("alarm fields do not fit the address space");
  end
endmodule

// File: rtl/cal_alarm_cmp_chk.sv
module cal_alarm_cmp_chk #(
  parameter int unsigned FIELD_W = 8,
  parameter int unsigned NF      = 5,
  parameter int unsigned AW      = 3
) (
  input logic                  clk,
  input logic                  rst_n,
  input logic                  sec_tick,
  input logic                  match,
  input logic                  flag,
  input logic                  rd_en,
  input logic                  bus_block,
  input logic [AW-1:0]         addr,
  input logic [FIELD_W-1:0]    rd_data,
  input logic [NF*FIELD_W-1:0] alarm_bits,
  input logic                  en
);
  // R3 / R10: a matching tick always leaves the flag set.
  a_r3_set_on_match: assert property (@(posedge clk) disable iff (!rst_n)
    (sec_tick && match) |=> flag);

  // R4: without a tick the flag cannot rise.
  a_r4_no_set_without_tick: assert property (@(posedge clk) disable iff (!rst_n)
    !sec_tick |=> !$rose(flag));

  // R7: an accepted status read with no competing match clears the flag.
  a_r7_read_clears: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en && !bus_block && addr == '0 && !(sec_tick && match)) |=> !flag);

  // R7 / R9: the status read returns the flag as it was before the edge.
  a_r7_read_returns_flag: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en && !bus_block && addr == '0) |=> (rd_data[6] == $past(flag)));

  // R11: lockout freezes the alarm bytes, the enable and the read data.
  a_r11_block_regs_stable: assert property (@(posedge clk) disable iff (!rst_n)
    bus_block |=> ($stable(alarm_bits) && $stable(en) && $stable(rd_data)));

  // R11: lockout also keeps the flag from being cleared by a read.
  a_r11_block_keeps_flag: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_block && flag) |=> flag);
endmodule

bind cal_alarm_cmp cal_alarm_cmp_chk #(
  .FIELD_W(FIELD_W),
  .NF     (NUM_FIELDS),
  .AW     (AW)
) u_chk (
  .clk       (clk),
  .rst_n     (rst_sync_n),
  .sec_tick  (sec_tick),
  .match     (match_w),
  .flag      (flag_w),
  .rd_en     (rd_en),
  .bus_block (bus_block),
  .addr      (addr),
  .rd_data   (rd_data),
  .alarm_bits(alarm_w),
  .en        (en_w)
);

// File: tb/cal_alarm_cmp_bench.sv
module cal_alarm_cmp_bench;
  logic       clk;
  logic       rst_n;
  logic       bus_block;
  logic       wr_en;
  logic       rd_en;
  logic [2:0] addr;
  logic [7:0] wdata;
  logic [7:0] rd_data;
  logic [7:0] cal_month, cal_date, cal_hour, cal_min, cal_sec;
  logic       sec_tick;
  logic       wdog_flag;
  logic       batt_low;
  logic       irq_n;

  int n_tests = 0;
  int n_fail  = 0;

  typedef struct {
    logic [7:0] val;
    string      tag;
  } exp_t;

  exp_t sb_q[$];
  logic mon_armed = 1'b0;

  cal_alarm_cmp u_cal_alarm_cmp (
    .clk      (clk),
    .rst_n    (rst_n),
    .bus_block(bus_block),
    .wr_en    (wr_en),
    .rd_en    (rd_en),
    .addr     (addr),
    .wdata    (wdata),
    .rd_data  (rd_data),
    .cal_month(cal_month),
    .cal_date (cal_date),
    .cal_hour (cal_hour),
    .cal_min  (cal_min),
    .cal_sec  (cal_sec),
    .sec_tick (sec_tick),
    .wdog_flag(wdog_flag),
    .batt_low (batt_low),
    .irq_n    (irq_n)
  );

  initial clk = 1'b0;
  always #4 clk = ~clk;

  // Monitor: compares each read result one edge after the strobe.
  always @(posedge clk) mon_armed <= rd_en;

  always @(negedge clk) begin
    exp_t e;
    if (mon_armed) begin
      n_tests++;
      if (sb_q.size() == 0) begin
        n_fail++;
        $display("FAIL scoreboard empty, rd_data=%02h", rd_data);
      end else begin
        e = sb_q.pop_front();
        if (rd_data !== e.val) begin
          n_fail++;
          $display("FAIL %s: rd_data=%02h expected %02h", e.tag, rd_data, e.val);
        end
      end
    end
  end

  task automatic chk(input logic [7:0] act, input logic [7:0] exp, input string tag);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: got %02h expected %02h", tag, act, exp);
    end
  endtask

  task automatic do_wr(input logic [2:0] a, input logic [7:0] d);
    wr_en = 1'b1; addr = a; wdata = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic do_rd(input logic [2:0] a, input logic [7:0] exp, input string tag);
    exp_t e;
    e.val = exp; e.tag = tag;
    sb_q.push_back(e);
    rd_en = 1'b1; addr = a;
    @(negedge clk);
    rd_en = 1'b0;
  endtask

  task automatic do_tick();
    sec_tick = 1'b1;
    @(negedge clk);
    sec_tick = 1'b0;
  endtask

  task automatic do_tick_rd(input logic [7:0] exp, input string tag);
    exp_t e;
    e.val = exp; e.tag = tag;
    sb_q.push_back(e);
    sec_tick = 1'b1; rd_en = 1'b1; addr = 3'd0;
    @(negedge clk);
    sec_tick = 1'b0; rd_en = 1'b0;
  endtask

  task automatic set_cal(input logic [7:0] mo, dt, hr, mi, se);
    cal_month = mo; cal_date = dt; cal_hour = hr; cal_min = mi; cal_sec = se;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog expired");
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    rst_n = 1'b0; bus_block = 1'b0; wr_en = 1'b0; rd_en = 1'b0;
    addr = '0; wdata = '0; sec_tick = 1'b0; wdog_flag = 1'b0; batt_low = 1'b0;
    set_cal(8'h01, 8'h01, 8'h00, 8'h00, 8'h00);
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // R1: reset state.
    chk({7'd0, irq_n}, 8'h01, "R1 irq_n after reset");
    chk(rd_data, 8'h00, "R1 rd_data after reset");
    do_rd(3'd0, 8'h00, "R1 status after reset");
    do_rd(3'd3, 8'h00, "R1 hour alarm after reset");

    // R2: program and read back the alarm time.
    do_wr(3'd1, 8'h30); do_wr(3'd2, 8'h59); do_wr(3'd3, 8'h23);
    do_wr(3'd4, 8'h15); do_wr(3'd5, 8'h07);
    do_rd(3'd1, 8'h30, "R2 second alarm");
    do_rd(3'd2, 8'h59, "R2 minute alarm");
    do_rd(3'd3, 8'h23, "R2 hour alarm");
    do_rd(3'd4, 8'h15, "R2 date alarm");
    do_rd(3'd5, 8'h07, "R2 month alarm");

    // R4: equal calendar but no tick.
    set_cal(8'h07, 8'h15, 8'h23, 8'h59, 8'h30);
    repeat (3) @(negedge clk);
    do_rd(3'd0, 8'h00, "R4 no flag without tick");

    // R12 / R8: enable on.
    do_wr(3'd0, 8'h20);
    do_rd(3'd0, 8'h20, "R12 enable readback");
    chk({7'd0, irq_n}, 8'h01, "R8 irq idle with enable only");

    // R6: one field differs.
    cal_sec = 8'h31;
    do_tick();
    do_rd(3'd0, 8'h20, "R6 mismatch keeps flag clear");

    // R3 / R7: exact match.
    cal_sec = 8'h30;
    do_tick();
    chk({7'd0, irq_n}, 8'h00, "R3 irq low after match");
    do_rd(3'd1, 8'h30, "R7 other address read");
    chk({7'd0, irq_n}, 8'h00, "R7 other read keeps flag");
    do_rd(3'd0, 8'h60, "R3 flag bit set");
    chk({7'd0, irq_n}, 8'h01, "R7 irq released after status read");
    do_rd(3'd0, 8'h20, "R7 flag cleared by read");

    // R8: enable off, flag still sets.
    do_wr(3'd0, 8'h00);
    do_tick();
    chk({7'd0, irq_n}, 8'h01, "R8 irq gated by enable");
    do_rd(3'd0, 8'h40, "R8 flag set with enable off");

    // R5: wildcards.
    do_wr(3'd1, 8'h80);
    cal_sec = 8'h05;
    do_tick();
    do_rd(3'd0, 8'h40, "R5 masked second");
    do_wr(3'd2, 8'h80); do_wr(3'd3, 8'h80); do_wr(3'd4, 8'h80); do_wr(3'd5, 8'h80);
    set_cal(8'h01, 8'h02, 8'h03, 8'h04, 8'h05);
    do_tick();
    do_rd(3'd0, 8'h40, "R5 all masked tick one");
    cal_sec = 8'h06;
    do_tick();
    do_rd(3'd0, 8'h40, "R5 all masked tick two");
    do_wr(3'd5, 8'h09);
    do_tick();
    do_rd(3'd0, 8'h00, "R6 unmasked month differs");
    do_wr(3'd5, 8'h80);

    // R10: tick and status read together.
    do_wr(3'd0, 8'h20);
    do_tick_rd(8'h20, "R10 read returns old flag");
    chk({7'd0, irq_n}, 8'h00, "R10 flag survives same-cycle read");
    do_rd(3'd0, 8'h60, "R10 flag readback");

    // R11: lockout.
    bus_block = 1'b1;
    do_wr(3'd1, 8'h11);
    do_wr(3'd0, 8'h00);
    do_rd(3'd1, 8'h60, "R11 blocked read holds rd_data");
    do_tick();
    chk({7'd0, irq_n}, 8'h00, "R11 alarm runs while blocked");
    do_rd(3'd0, 8'h60, "R11 blocked status read holds rd_data");
    chk({7'd0, irq_n}, 8'h00, "R11 blocked read does not clear");
    bus_block = 1'b0;
    @(negedge clk);
    do_rd(3'd1, 8'h80, "R11 blocked write ignored");
    do_rd(3'd0, 8'h60, "R11 flag and enable kept");

    // R9 / R12: shared status bits and unused addresses.
    wdog_flag = 1'b1; batt_low = 1'b1;
    do_rd(3'd0, 8'hB0, "R9 status layout");
    do_wr(3'd6, 8'hFF);
    do_rd(3'd6, 8'h00, "R12 address 6 reads zero");
    do_rd(3'd7, 8'h00, "R12 address 7 reads zero");
    do_rd(3'd1, 8'h80, "R12 write to 6 ignored");
    do_wr(3'd0, 8'hDF);
    do_rd(3'd0, 8'h90, "R12 status write touches enable only");

    repeat (3) @(negedge clk);
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule